// File: doc/BRIEF.md
# Two-by-Two Packet Switch with Qualified-Packet Tally

The block moves fixed-width packets from two input queues to two output queues. A producer pushes a packet into either input queue through a valid/ready handshake. On every clock edge, the packets at the heads of the input queues may move to the output queue picked by their bit 0. A consumer drains each output queue through its own valid/ready handshake.

Alongside the data path, a wrapping counter tallies qualified packets as they cross from an input queue to an output queue. A packet is qualified when bits 3, 2 and 1 are all zero. The counter can step by only one per cycle, so two qualified packets never cross in the same cycle. In that case input 0 moves and input 1 waits. Apart from that rule, and apart from the two inputs contending for one output, both heads move together whenever their destinations have room.

Top module: `pkt_switch2x2`

## Requirements
- R1: While reset is high and on the first cycle after it, every queue is empty: both `in_ready` bits are 1, both `out_valid` bits are 0 and `count` is 0.
- R2: Each input queue holds up to DEPTH packets. `in_ready[i]` is 1 exactly when that queue is not full. A packet is accepted on an edge where `in_valid[i]` and `in_ready[i]` are both 1.
- R3: A packet moves to output queue `pkt[0]` (0 selects output 0, 1 selects output 1). Packets leave each output in the order in which they entered it.
- R4: A head packet moves only if its input queue is non-empty and its destination output queue is not full before the edge. A dequeue on the same edge does not free room. Otherwise the packet stays at the head.
- R5: When both heads target the same output and that output has room, input 0 moves and input 1 waits.
- R6: When both heads are qualified (bits 3..1 equal 000) and both could move, input 0 moves and input 1 waits.
- R7: When the heads target different outputs, both outputs have room and the heads are not both qualified, both packets move on the same edge.
- R8: `count` rises by exactly one on each edge where a qualified packet moves, and never changes otherwise.
- R9: `count` wraps modulo 2^CNT_W.
- R10: `out_valid[j]` is 1 exactly when output queue j is non-empty, and `out_data[j]` shows its oldest packet. The packet is removed on an edge where `out_valid[j]` and `out_ready[j]` are both 1.
- R11: A packet accepted on edge N moves on edge N+1 at the earliest, and is visible at the output from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Enqueue request per input |
| in_data | input | 2*PKT_W | Packet per input, packed [1:0][PKT_W-1:0] |
| in_ready | output | 2 | Input queue has room |
| out_valid | output | 2 | Output queue non-empty |
| out_data | output | 2*PKT_W | Oldest packet per output, packed [1:0][PKT_W-1:0] |
| out_ready | input | 2 | Consumer takes the shown packet |
| count | output | CNT_W | Qualified-packet tally |

## Verification
An enqueue on edge N shows up in `in_ready` right after N. The move to an output, and the matching counter step, happen on edge N+1, so `out_valid`, `out_data` and `count` reflect the packet two edges after it was driven. The bench drives stimulus at the falling edge and then advances its queue-based model by exactly one rising edge. It compares every output at the following falling edge, so each result is sampled in the cycle it is due. The directed checks for the arbitration cases use the same cycle count: nothing visible after the first edge, the arbitration outcome after the second.

// File: rtl/pktsw_pkg.sv
package pktsw_pkg;

    typedef struct packed {
        logic go;
        logic dst;
        logic hit;
    } lane_t;

    function automatic logic tag_hit(input logic [2:0] b);
        return b == 3'b000;
    endfunction

endpackage

// File: rtl/sw_fifo.sv
module sw_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] n;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
            n  <= '0;
        end else begin
            if (push) wp <= step_ptr(wp);
            if (pop)  rp <= step_ptr(rp);
            case ({push, pop})
                2'b10:   n <= n + 1'b1;
                2'b01:   n <= n - 1'b1;
                default: n <= n;
            endcase
        end
    end

    assign head  = mem[rp];
    assign empty = (n == '0);
    assign full  = (n == CW'(DEPTH));
endmodule

// File: rtl/sw_arbiter.sv
module sw_arbiter
    import pktsw_pkg::*;
(
    input  logic        [1:0] vld,
    input  logic        [1:0] dst,
    input  logic        [1:0] hit,
    input  logic        [1:0] out_full,
    output lane_t       [1:0] lane,
    output logic              inc
);
    logic go0, go1;

    always_comb begin
        go0 = vld[0] && !out_full[dst[0]];
        go1 = vld[1] && !out_full[dst[1]]
              && !(go0 && (dst[0] == dst[1]))
              && !(go0 && hit[0] && hit[1]);
        lane[0] = '{go: go0, dst: dst[0], hit: hit[0]};
        lane[1] = '{go: go1, dst: dst[1], hit: hit[1]};
        inc = (go0 && hit[0]) || (go1 && hit[1]);
    end
endmodule

// File: rtl/sw_counter.sv
module sw_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/pkt_switch2x2.sv
module pkt_switch2x2
    import pktsw_pkg::*;
#(
    parameter int PKT_W = 8,
    parameter int DEPTH = 2,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            in_valid,
    input  logic [1:0][PKT_W-1:0] in_data,
    output logic [1:0]            in_ready,
    output logic [1:0]            out_valid,
    output logic [1:0][PKT_W-1:0] out_data,
    input  logic [1:0]            out_ready,
    output logic [CNT_W-1:0]      count
);
    logic [1:0][PKT_W-1:0] in_head;
    logic [1:0][PKT_W-1:0] out_wdata;
    logic [1:0]            in_empty, in_full;
    logic [1:0]            out_empty, out_full, out_push;
    logic [1:0]            head_dst, head_hit;
    lane_t [1:0]           lane;
    logic                  inc;

    for (genvar i = 0; i < 2; i++) begin : g_in
        sw_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_in (
            .clk       (clk),
            .rst       (rst),
            .push      (in_valid[i] && !in_full[i]),
            .push_data (in_data[i]),
            .pop       (lane[i].go),
            .head      (in_head[i]),
            .empty     (in_empty[i]),
            .full      (in_full[i])
        );
        assign in_ready[i] = !in_full[i];
        assign head_dst[i] = in_head[i][0];
        assign head_hit[i] = tag_hit(in_head[i][3:1]);
    end

    sw_arbiter u_arb (
        .vld      (~in_empty),
        .dst      (head_dst),
        .hit      (head_hit),
        .out_full (out_full),
        .lane     (lane),
        .inc      (inc)
    );

    for (genvar j = 0; j < 2; j++) begin : g_out
        logic from0, from1;
        assign from0        = lane[0].go && (lane[0].dst == 1'(j));
        assign from1        = lane[1].go && (lane[1].dst == 1'(j));
        assign out_push[j]  = from0 || from1;
        assign out_wdata[j] = from0 ? in_head[0] : in_head[1];

        sw_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_out (
            .clk       (clk),
            .rst       (rst),
            .push      (out_push[j]),
            .push_data (out_wdata[j]),
            .pop       (out_ready[j] && !out_empty[j]),
            .head      (out_data[j]),
            .empty     (out_empty[j]),
            .full      (out_full[j])
        );
        assign out_valid[j] = !out_empty[j];
    end

    sw_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc),
        .value (count)
    );
endmodule

// File: rtl/pkt_switch2x2_chk.sv
module pkt_switch2x2_chk
    import pktsw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input lane_t [1:0]      lane,
    input logic [1:0]       vld,
    input logic [1:0]       out_full,
    input logic [1:0]       out_push,
    input logic [CNT_W-1:0] count
);
    logic hit_move;
    assign hit_move = (lane[0].go && lane[0].hit) || (lane[1].go && lane[1].hit);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (out_push & out_full) == 2'b00);                                         // R4
    AST_DST_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (lane[0].go && lane[1].go) |-> (lane[0].dst != lane[1].dst));            // R5
    AST_IN0_FIRST: assert property (@(posedge clk) disable iff (rst)
        (vld[0] && !out_full[lane[0].dst]) |-> lane[0].go);                      // R5
    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        !(lane[0].go && lane[0].hit && lane[1].go && lane[1].hit));              // R6
    AST_PAIR_MOVE: assert property (@(posedge clk) disable iff (rst)
        (vld == 2'b11 && lane[0].dst != lane[1].dst && !out_full[lane[0].dst]
         && !out_full[lane[1].dst] && !(lane[0].hit && lane[1].hit))
        |-> (lane[0].go && lane[1].go));                                         // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R8
    AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
        hit_move |=> count == CNT_W'($past(count) + 1'b1));                     // R8
endmodule

bind pkt_switch2x2 pkt_switch2x2_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lane     (lane),
    .vld      (~in_empty),
    .out_full (out_full),
    .out_push (out_push),
    .count    (count)
);

// File: tb/pkt_switch2x2_bench.sv
`timescale 1ns/1ps
module pkt_switch2x2_bench;
    localparam int PW = 8;
    localparam int DEPTH = 2;
    localparam int CW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        in_valid = '0;
    logic [1:0][PW-1:0] in_data = '0;
    logic [1:0]        in_ready;
    logic [1:0]        out_valid;
    logic [1:0][PW-1:0] out_data;
    logic [1:0]        out_ready = '0;
    logic [CW-1:0]     count;

    int tests = 0;
    int fails = 0;

    logic [PW-1:0] mq_in  [0:1][$];
    logic [PW-1:0] mq_out [0:1][$];
    int            mcnt = 0;

    always #2 clk = ~clk;

    pkt_switch2x2 #(.PKT_W(PW), .DEPTH(DEPTH), .CNT_W(CW)) u_pkt_switch2x2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .count(count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        for (int i = 0; i < 2; i++) begin
            chk(in_ready[i] == (mq_in[i].size() < DEPTH), "R2 in_ready", in_ready[i], mq_in[i].size() < DEPTH);
            chk(out_valid[i] == (mq_out[i].size() > 0), "R4 R10 out_valid", out_valid[i], mq_out[i].size() > 0);
            if (mq_out[i].size() > 0)
                chk(out_data[i] == mq_out[i][0], "R3 out_data", out_data[i], mq_out[i][0]);
        end
        chk(count == CW'(mcnt), "R8 R9 count", count, CW'(mcnt));
    endtask

    task automatic step(input logic [1:0] iv, input logic [PW-1:0] d0, input logic [PW-1:0] d1,
                        input logic [1:0] ordy);
        bit [1:0] hv, hd, hh, fl, ir, ov;
        bit g0, g1;
        in_valid = iv;
        in_data = {d1, d0};
        out_ready = ordy;
        for (int i = 0; i < 2; i++) begin
            hv[i] = mq_in[i].size() > 0;
            hd[i] = hv[i] ? mq_in[i][0][0] : 1'b0;
            hh[i] = hv[i] ? (mq_in[i][0][3:1] == 3'b000) : 1'b0;
            fl[i] = mq_out[i].size() >= DEPTH;
            ir[i] = mq_in[i].size() < DEPTH;
            ov[i] = mq_out[i].size() > 0;
        end
        g0 = hv[0] && !fl[hd[0]];
        g1 = hv[1] && !fl[hd[1]] && !(g0 && hd[0] == hd[1]) && !(g0 && hh[0] && hh[1]);
        for (int j = 0; j < 2; j++)
            if (ordy[j] && ov[j]) void'(mq_out[j].pop_front());
        if (g0) mq_out[hd[0]].push_back(mq_in[0].pop_front());
        if (g1) mq_out[hd[1]].push_back(mq_in[1].pop_front());
        if ((g0 && hh[0]) || (g1 && hh[1])) mcnt++;
        if (iv[0] && ir[0]) mq_in[0].push_back(d0);
        if (iv[1] && ir[1]) mq_in[1].push_back(d1);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        out_ready = '0;
        for (int i = 0; i < 2; i++) begin
            mq_in[i].delete();
            mq_out[i].delete();
        end
        mcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 2'b11 && out_valid == 2'b00 && count == '0, "R1 during reset",
            {in_ready, out_valid}, 4'b1100);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(in_ready == 2'b11 && out_valid == 2'b00 && count == '0, "R1 after reset",
            {in_ready, out_valid}, 4'b1100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R6: both qualified, different outputs
        step(2'b11, 8'h00, 8'h01, 2'b00);
        chk(out_valid == 2'b00, "R11 nothing after first edge", out_valid, 0);
        step(2'b00, 0, 0, 2'b00);
        chk(out_valid == 2'b01 && count == 1, "R6 only input 0 moves", {out_valid, count}, {2'b01, 8'd1});
        step(2'b00, 0, 0, 2'b00);
        chk(out_valid == 2'b11 && count == 2, "R6 input 1 follows", {out_valid, count}, {2'b11, 8'd2});

        do_reset();
        // R7: one qualified, different outputs
        step(2'b11, 8'h02, 8'h01, 2'b00);
        step(2'b00, 0, 0, 2'b00);
        chk(out_valid == 2'b11 && count == 1, "R7 pair moves together", {out_valid, count}, {2'b11, 8'd1});

        do_reset();
        // R5: same destination
        step(2'b11, 8'h02, 8'h04, 2'b00);
        step(2'b00, 0, 0, 2'b00);
        chk(out_valid == 2'b01 && out_data[0] == 8'h02, "R5 input 0 first", out_data[0], 8'h02);
        step(2'b00, 0, 0, 2'b01);
        chk(out_valid == 2'b01 && out_data[0] == 8'h04, "R10 dequeue shows next", out_data[0], 8'h04);
        step(2'b00, 0, 0, 2'b01);
        chk(out_valid == 2'b00, "R10 output drained", out_valid, 0);

        do_reset();
        // R4: destination full holds packets
        for (int k = 0; k < DEPTH + 2; k++) step(2'b01, 8'h10 + PW'(2 * k), 0, 2'b00);
        repeat (3) step(2'b00, 0, 0, 2'b00);
        chk(out_data[0] == 8'h10, "R4 oldest held at output", out_data[0], 8'h10);
        chk(in_ready[0] == (DEPTH > 2), "R2 input backs up", in_ready[0], DEPTH > 2);

        // random traffic
        do_reset();
        for (int c = 0; c < 4000; c++)
            step(2'($urandom), PW'($urandom), PW'($urandom), 2'($urandom | $urandom));
        repeat (10) step(2'b00, 0, 0, 2'b11);

        // R9: wrap
        do_reset();
        for (int c = 0; c < 300; c++) step(2'b11, 8'h00, 8'h01, 2'b11);
        repeat (10) step(2'b00, 0, 0, 2'b11);
        chk(mcnt > (1 << CW) && count == CW'(mcnt), "R9 counter wrapped", count, CW'(mcnt));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule